// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a synchronous host and an asynchronous 64K x 4 static RAM. The host raises a one-cycle request carrying a direction flag, a 16-bit word address and, for writes, a 4-bit data word. The block turns that into a chip-select, write-enable and output-enable sequence, all active low, on the memory pins. It drives the shared 4-bit data bus only when it owns it. When the access ends it pulses a done strobe, and for reads it returns the captured word alongside that pulse.

Every minimum timing window of the memory is a parameter in nanoseconds. The block converts each one to a whole number of clock cycles with a ceiling division, and a window is never shorter than one cycle. Between accesses the memory is held in standby with chip-select high. The address pins change only while chip-select is high. Write-enable is never pulled low while output-enable is low. After a read, a release window must pass before the block turns its data drivers on again.

Top module: `sram_ctl`

## Requirements
- R1: While reset is applied and on the first cycle after it, chip-select, write-enable and output-enable are high (1), the data-bus drive enable is 0 and done is 0.
- R2: Whenever the sequencer is idle, chip-select is high (standby) and the data bus is not driven by the block.
- R3: Write-enable is low only while chip-select is low, and output-enable stays high for every cycle in which write-enable is low.
- R4: The address pins change only in a cycle where chip-select is high, so they are stable across the whole of every write overlap (chip-select low and write-enable low).
- R5: A write overlap lasts at least N_WP cycles, where N_WP is the largest of the cycle counts for write pulse, address-to-end-of-write, select-to-end-of-write and data setup. The block drives the write data on the bus from the cycle before the overlap through the cycle after it.
- R6: A read holds chip-select low, write-enable high and output-enable low for N_RD cycles, where N_RD is the largest of the cycle counts for address access, select access and output-enable access. The block never drives the bus while output-enable is low, and the word on the bus at the last such cycle is returned on host read data.
- R7: After a read, the block waits more than N_HZ cycles after output-enable was last low before it turns on its data drivers. N_HZ is the cycle count of the output release time.
- R8: Done is high for exactly one cycle per accepted access. The request-to-done latency is 1 + N_AS + N_WP + N_HOLD cycles for a write and 1 + N_AS + N_RD + N_HZ cycles for a read, where host write is 1 for a write and 0 for a read.
- R9: A request is accepted only when the sequencer is idle; a request raised during an access is ignored and writes nothing.
- R10: Each window count is ceil(time_ns / CLK_PERIOD_NS), raised to 1 when that gives 0. A zero-nanosecond setup or hold window therefore still takes one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Access request, sampled only when idle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Captured read data, valid with done |
| host_done | output | 1 | One-cycle end-of-access pulse |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_cs_n | output | 1 | Chip-select, active low |
| mem_we_n | output | 1 | Write-enable, active low |
| mem_oe_n | output | 1 | Output-enable, active low |
| mem_dq | inout | DATA_W | Bidirectional memory data bus |
| mem_dq_oe | output | 1 | 1 while the block drives mem_dq |

## Verification
The assertions check the pin rules on every cycle:
- standby when idle;
- write-enable only inside chip-select, with output-enable high;
- address stability across the overlap;
- no drive while output-enable is low;
- write data present during the overlap;
- the single-cycle done pulse and acceptance only from idle.

Only the bench scenarios can show the rest:
- that the right word lands in the memory and comes back;
- that overlap widths, release windows and latencies match the ceiling-derived counts;
- that a request made during an access is dropped.

// File: rtl/sram_ctl_pkg.sv
// Shared types and window arithmetic for the static RAM access sequencer.
// Assumes all timing parameters are non-negative nanosecond integers.
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_STROBE = 3'd2,
        ST_HOLD   = 3'd3,
        ST_TURN   = 3'd4
    } seq_state_e;

    // Cycles needed to cover a window of ns, never fewer than one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
        int unsigned c;
        c = (ns + period - 1) / period;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max_of2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
// Access sequencer: walks IDLE -> SETUP -> STROBE -> HOLD (write) or
// TURN (read) -> IDLE, timing each state with one shared down-counter.
// Assumes every window count is at least one cycle.
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int unsigned N_AS   = 1,
    parameter int unsigned N_WP   = 1,
    parameter int unsigned N_RD   = 1,
    parameter int unsigned N_HOLD = 1,
    parameter int unsigned N_HZ   = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       req_wr,
    output seq_state_e state_q,
    output seq_state_e state_d,
    output logic       wr_q,
    output logic       wr_d,
    output logic       accept,
    output logic       done
);

    localparam int unsigned N_MAX = max_of2(max_of2(max_of2(N_AS, N_WP), max_of2(N_RD, N_HOLD)), N_HZ);
    localparam int unsigned CNT_W = (N_MAX < 2) ? 1 : $clog2(N_MAX);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_load;
    logic             cnt_zero;

    assign cnt_zero = (cnt_q == '0);
    assign accept   = (state_q == ST_IDLE) && req;
    assign wr_d     = accept ? req_wr : wr_q;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (req) state_d = ST_SETUP;
            ST_SETUP:  if (cnt_zero) state_d = ST_STROBE;
            ST_STROBE: if (cnt_zero) state_d = wr_q ? ST_HOLD : ST_TURN;
            ST_HOLD:   if (cnt_zero) state_d = ST_IDLE;
            ST_TURN:   if (cnt_zero) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Length of the state about to be entered, minus one.
    always_comb begin
        case (state_d)
            ST_SETUP:  cnt_load = CNT_W'(N_AS - 1);
            ST_STROBE: cnt_load = wr_d ? CNT_W'(N_WP - 1) : CNT_W'(N_RD - 1);
            ST_HOLD:   cnt_load = CNT_W'(N_HOLD - 1);
            ST_TURN:   cnt_load = CNT_W'(N_HZ - 1);
            default:   cnt_load = '0;
        endcase
    end

    // State, operation flag and window counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wr_q    <= 1'b0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            wr_q    <= wr_d;
            if (state_d != state_q) cnt_q <= cnt_load;
            else if (!cnt_zero)     cnt_q <= cnt_q - 1'b1;
        end
    end

    // One-cycle completion pulse on return to IDLE.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= (state_d == ST_IDLE) && (state_q != ST_IDLE);
    end

    // R9: an access can only begin from IDLE.
    p_start_from_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETUP && $past(state_q) != ST_SETUP) |-> $past(state_q) == ST_IDLE);

    // R8: done never lasts two cycles.
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/sram_ctl_pins.sv
// Pin stage: registers the memory strobes, address and write data from the
// sequencer's next state so the pins change only at clock edges, and
// captures read data on the final strobe cycle.
// Assumes state_d/wr_d are the values the sequencer loads this edge.
module sram_ctl_pins
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  seq_state_e        state_q,
    input  seq_state_e        state_d,
    input  logic              wr_q,
    input  logic              wr_d,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_dq_oe
);

    logic busy_d;
    logic last_rd_strobe;

    assign busy_d         = (state_d == ST_SETUP) || (state_d == ST_STROBE) || (state_d == ST_HOLD);
    assign last_rd_strobe = (state_q == ST_STROBE) && (state_d != ST_STROBE) && !wr_q;

    // Address and write data latch only when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else if (accept) begin
            mem_addr  <= host_addr;
            mem_wdata <= host_wdata;
        end
    end

    // Strobe and drive-enable registers decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_cs_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_cs_n  <= !busy_d;
            mem_we_n  <= !((state_d == ST_STROBE) && wr_d);
            mem_oe_n  <= !((state_d == ST_STROBE) && !wr_d);
            mem_dq_oe <= busy_d && wr_d;
        end
    end

    // Read data capture at the end of the output-enable window.
    always_ff @(posedge clk) begin
        if (!rst_n)              host_rdata <= '0;
        else if (last_rd_strobe) host_rdata <= mem_dq_in;
    end

    // R3: write-enable is only low inside chip-select.
    p_we_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_cs_n);

    // R3: output-enable stays high whenever write-enable is low.
    p_oe_off_in_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    // R4: address held across consecutive overlap cycles.
    p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !mem_we_n && $past(!mem_cs_n && !mem_we_n)) |-> $stable(mem_addr));

    // R5: write data is on the bus during the overlap.
    p_data_in_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);

    // R6: no controller drive while the memory's outputs are enabled.
    p_no_clash_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);

endmodule

// File: rtl/sram_ctl.sv
// Top of the static RAM access sequencer: converts nanosecond windows to
// cycle counts, joins the sequencer and pin stage, and owns the tri-state
// data bus. Assumes a single host and one memory device.
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 16,
    parameter int unsigned DATA_W        = 4,
    parameter int unsigned CLK_PERIOD_NS = 20,
    parameter int unsigned T_AS_NS       = 0,
    parameter int unsigned T_WP_NS       = 9,
    parameter int unsigned T_AW_NS       = 9,
    parameter int unsigned T_CW_NS       = 9,
    parameter int unsigned T_DW_NS       = 6,
    parameter int unsigned T_WR_NS       = 0,
    parameter int unsigned T_DH_NS       = 0,
    parameter int unsigned T_AA_NS       = 12,
    parameter int unsigned T_ACS_NS      = 12,
    parameter int unsigned T_OE_NS       = 6,
    parameter int unsigned T_HZ_NS       = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    inout  wire  [DATA_W-1:0] mem_dq,
    output logic              mem_dq_oe
);

    localparam int unsigned N_AS   = ns_to_cyc(T_AS_NS, CLK_PERIOD_NS);
    localparam int unsigned N_WP   = max_of2(max_of2(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                                     ns_to_cyc(T_AW_NS, CLK_PERIOD_NS)),
                                             max_of2(ns_to_cyc(T_CW_NS, CLK_PERIOD_NS),
                                                     ns_to_cyc(T_DW_NS, CLK_PERIOD_NS)));
    localparam int unsigned N_RD   = max_of2(max_of2(ns_to_cyc(T_AA_NS, CLK_PERIOD_NS),
                                                     ns_to_cyc(T_ACS_NS, CLK_PERIOD_NS)),
                                             ns_to_cyc(T_OE_NS, CLK_PERIOD_NS));
    localparam int unsigned N_HOLD = max_of2(ns_to_cyc(T_WR_NS, CLK_PERIOD_NS),
                                             ns_to_cyc(T_DH_NS, CLK_PERIOD_NS));
    localparam int unsigned N_HZ   = ns_to_cyc(T_HZ_NS, CLK_PERIOD_NS);

    seq_state_e        state_q;
    seq_state_e        state_d;
    logic              wr_q;
    logic              wr_d;
    logic              accept;
    logic [DATA_W-1:0] wdata_pin;

    sram_ctl_seq #(
        .N_AS   (N_AS),
        .N_WP   (N_WP),
        .N_RD   (N_RD),
        .N_HOLD (N_HOLD),
        .N_HZ   (N_HZ)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (host_req),
        .req_wr  (host_wr),
        .state_q (state_q),
        .state_d (state_d),
        .wr_q    (wr_q),
        .wr_d    (wr_d),
        .accept  (accept),
        .done    (host_done)
    );

    sram_ctl_pins #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .state_q    (state_q),
        .state_d    (state_d),
        .wr_q       (wr_q),
        .wr_d       (wr_d),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .mem_dq_in  (mem_dq),
        .host_rdata (host_rdata),
        .mem_addr   (mem_addr),
        .mem_wdata  (wdata_pin),
        .mem_cs_n   (mem_cs_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_dq_oe  (mem_dq_oe)
    );

    // Tri-state driver for the shared data bus.
    assign mem_dq = mem_dq_oe ? wdata_pin : {DATA_W{1'bz}};

    // R2: idle sequencer leaves the memory in standby with the bus released.
    p_idle_standby_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (mem_cs_n && !mem_dq_oe));

endmodule

// File: tb/tb_sram_ctl.sv
module tb_sram_ctl;

    localparam int unsigned PER   = 20;
    localparam int unsigned WP_NS = 45;
    localparam int unsigned AA_NS = 50;
    localparam int unsigned HZ_NS = 30;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + PER - 1) / PER;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int AS_CYC = cyc(0);
    localparam int WP_CYC = cyc(WP_NS);
    localparam int RD_CYC = cyc(AA_NS);
    localparam int HD_CYC = cyc(0);
    localparam int HZ_CYC = cyc(HZ_NS);
    localparam int LAT_W  = 1 + AS_CYC + WP_CYC + HD_CYC;
    localparam int LAT_R  = 1 + AS_CYC + RD_CYC + HZ_CYC;

    // {wr, addr[15:0], data[3:0]}: write data or expected read word
    localparam logic [20:0] VEC [11] = '{
        {1'b1, 16'h0000, 4'hA}, {1'b1, 16'hFFFF, 4'h5}, {1'b1, 16'h1234, 4'hC},
        {1'b0, 16'h0000, 4'hA}, {1'b0, 16'hFFFF, 4'h5}, {1'b0, 16'h1234, 4'hC},
        {1'b1, 16'h0000, 4'h3}, {1'b0, 16'h0000, 4'h3}, {1'b1, 16'h8001, 4'hF},
        {1'b0, 16'h8001, 4'hF}, {1'b0, 16'h0001, 4'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic [15:0] host_addr = '0;
    logic [3:0]  host_wdata = '0;
    logic [3:0]  host_rdata;
    logic        host_done;
    logic [15:0] mem_addr;
    logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    wire  [3:0]  mem_dq;

    int checks = 0;
    int errors = 0;

    always #(PER/2) clk = ~clk;

    sram_ctl #(
        .CLK_PERIOD_NS (PER),
        .T_WP_NS       (WP_NS),
        .T_AA_NS       (AA_NS),
        .T_HZ_NS       (HZ_NS)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .host_done  (host_done),
        .mem_addr   (mem_addr),
        .mem_cs_n   (mem_cs_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_dq     (mem_dq),
        .mem_dq_oe  (mem_dq_oe)
    );

    // Behavioural memory: sparse storage, drives the bus during a read.
    logic [3:0] mem [logic [15:0]];
    logic       mdrv_en;
    logic [3:0] mdrv_val;
    always @* begin
        mdrv_en  = !mem_cs_n && !mem_oe_n && mem_we_n;
        mdrv_val = mem.exists(mem_addr) ? mem[mem_addr] : 4'h0;
    end
    assign mem_dq = mdrv_en ? mdrv_val : 4'bzzzz;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Pin-level monitor: overlap rules, widths, commits, contention, release.
    bit         prev_ovl = 0;
    bit         prev_dq_oe = 0;
    logic [15:0] prev_addr = '0;
    int         ovl_w = 0;
    logic [15:0] ovl_addr = '0;
    logic [3:0] ovl_data = '0;
    int         since_rd = 100;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_cs_n && !mem_we_n) begin
                if (!prev_ovl) chk(prev_dq_oe, "R5 data before overlap", prev_dq_oe, 1);
                else if (mem_addr != prev_addr) chk(0, "R4 address moved in overlap", mem_addr, prev_addr);
                if (!mem_oe_n) chk(0, "R3 oe low during write", mem_oe_n, 1);
                if (!mem_dq_oe) chk(0, "R5 data not driven in overlap", mem_dq_oe, 1);
                ovl_w++;
                ovl_addr = mem_addr;
                ovl_data = mem_dq;
            end else if (prev_ovl) begin
                chk(ovl_w >= WP_CYC, "R5 overlap width", ovl_w, WP_CYC);
                chk(mem_dq_oe, "R5 data after overlap", mem_dq_oe, 1);
                mem[ovl_addr] = ovl_data;
                ovl_w = 0;
            end
            if (!mem_we_n && mem_cs_n) chk(0, "R3 we low without cs", mem_cs_n, 0);
            if (mdrv_en) begin
                if (mem_dq_oe) chk(0, "R6 contention", mem_dq_oe, 0);
                since_rd = 0;
            end else if (since_rd < 100) since_rd++;
            if (mem_dq_oe && since_rd <= HZ_CYC) chk(0, "R7 drive too soon after read", since_rd, HZ_CYC + 1);
            prev_ovl   = !mem_cs_n && !mem_we_n;
            prev_dq_oe = mem_dq_oe;
            prev_addr  = mem_addr;
        end
    end

    task automatic do_op(input bit wr, input logic [15:0] a, input logic [3:0] d,
                         output logic [3:0] rd, output int lat);
        @(negedge clk);
        host_req = 1; host_wr = wr; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 0;
        lat = 1;
        while (!host_done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        rd = host_rdata;
        @(negedge clk);
        chk(!host_done, "R8 done single cycle", host_done, 0);
        chk(mem_cs_n && !mem_dq_oe, "R2 standby after access", {mem_cs_n, mem_dq_oe}, 2);
    endtask

    bit finished = 0;

    initial begin
        logic [3:0] rd;
        int lat;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(mem_cs_n && mem_we_n && mem_oe_n, "R1 strobes in reset",
            {mem_cs_n, mem_we_n, mem_oe_n}, 7);
        chk(!mem_dq_oe && !host_done, "R1 bus and done in reset", {mem_dq_oe, host_done}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !host_done,
            "R1 first cycle after reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, host_done}, 5'b11100);

        for (int i = 0; i < 11; i++) begin
            do_op(VEC[i][20], VEC[i][19:4], VEC[i][3:0], rd, lat);
            // R8/R10: latency from ceiling-derived window counts
            chk(lat == (VEC[i][20] ? LAT_W : LAT_R), "R8 R10 latency", lat,
                VEC[i][20] ? LAT_W : LAT_R);
            if (!VEC[i][20]) chk(rd == VEC[i][3:0], "R6 read data", rd, VEC[i][3:0]);
        end

        // R9: request raised during an access is dropped
        @(negedge clk);
        host_req = 1; host_wr = 1; host_addr = 16'h00AA; host_wdata = 4'h7;
        @(negedge clk);
        host_addr = 16'h00BB; host_wdata = 4'h9;
        @(negedge clk);
        host_req = 0;
        while (!host_done) @(negedge clk);
        do_op(0, 16'h00BB, 4'h0, rd, lat);
        chk(rd == 4'h0, "R9 busy request ignored", rd, 0);
        do_op(0, 16'h00AA, 4'h0, rd, lat);
        chk(rd == 4'h7, "R9 first request written", rd, 7);

        // R7: write straight after a read waits out the release window
        do_op(1, 16'h00AA, 4'h2, rd, lat);
        do_op(0, 16'h00AA, 4'h0, rd, lat);
        chk(rd == 4'h2, "R7 R6 read after turnaround", rd, 2);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule